// File: doc/BRIEF.md
# I2C Bus Monitor and Bit-Rate Generator

This block is the control core of a simple I2C port. It keeps a small register-mapped control word holding an enable bit and a 3-bit speed code. From the system clock it derives a half-bit-period tick that a master-mode engine uses to toggle SCL. It watches the sampled SCL and SDA levels for START and STOP conditions and keeps a bus-busy flag. Software reads this flag before it starts a transfer.

A second register holds two pin-ownership bits. Each bit hands one of the two shared port pins either to the I2C function or to ordinary I/O. Byte shifting, acknowledge handling and slave addressing belong to neighbouring logic and are not part of this block. Register access is a single-cycle write strobe with a one-bit address; the read data is a combinational view of the addressed register.

Top module: `i2c_bus_ctrl`

## Requirements
- R1: After reset, the control register (address 0) reads 0x01: disabled, speed code 001. The pin register (address 1) reads 0x00. `busBusy`, `sclTick`, `sdaPinSel` and `sclPinSel` are all 0.
- R2: While the enable bit (control bit 7) is 0, `sclTick` stays 0, and a START condition on the lines does not set `busBusy`.
- R3: With enable set and speed code c (control bits 2:0), `sclTick` is a one-cycle pulse repeating every 16·2^c clocks. Code 000 gives 16 and code 111 gives 2048, which is half of a bit period of 32·2^c clocks.
- R4: Any write to the control register restarts the rate counter. The first tick comes 16·2^c − 1 clock edges after the write edge; sampled between edges, the cycle just after the write edge counts as cycle 0.
- R5: SDA falling while SCL is high (a START), seen through a two-flop synchronizer, sets `busBusy`. The flag is 1 at the third rising clock edge after the SDA change and still 0 after the second.
- R6: SDA rising while SCL is high (a STOP) clears `busBusy`.
- R7: SDA changes while SCL is low leave `busBusy` unchanged.
- R8: `busBusy` is forced to 0 while the interface is disabled, including when a control write clears the enable bit.
- R9: The control register reads enable in bit 7, the busy flag in bit 3 and the speed code in bits 2:0. Bits 6:4 read 0. Writes to bits 6:3 have no effect.
- R10: In the pin register (address 1), bit 7 drives `sdaPinSel` and bit 6 drives `sclPinSel` (1 hands the pin to I2C). Bits 5:0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | 1 | Register select: 0 control, 1 pin ownership |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the addressed register |
| sclIn | input | 1 | Sampled SCL line level |
| sdaIn | input | 1 | Sampled SDA line level |
| busBusy | output | 1 | Bus-busy flag |
| sclTick | output | 1 | Half-bit-period tick for a master engine |
| sdaPinSel | output | 1 | 1: SDA pin owned by I2C |
| sclPinSel | output | 1 | 1: SCL pin owned by I2C |

## Verification
The assertions check on every cycle that:
- the tick is always a single-cycle pulse, is silent while disabled, and is never high right after a control write;
- the busy flag never rises while disabled and drops one cycle after the enable bit is seen low;
- the pin selects follow the last pin-register write;
- unused control bits read 0.

Only the bench scenarios can show the exact tick spacing for every speed code, the first-tick delay after a restart, the synchronizer latency of START detection, and that STOP clears the flag and SDA activity with SCL low does not change it.

// File: rtl/i2c_bus_pkg.sv
package i2c_bus_pkg;
  localparam int SPEED_W = 3;

  // strobes from the register control to the datapath
  typedef struct packed {
    logic               enable;
    logic [SPEED_W-1:0] speedCode;
    logic               restartDiv;
  } ctrlStrobe_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  // idle bus level is high, so the chain resets to ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_bus_regs.sv
module i2c_bus_regs
  import i2c_bus_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int EN_BIT      = 7,
  parameter int BUSY_BIT    = 3,
  parameter int SDA_OWN_BIT = 7,
  parameter int SCL_OWN_BIT = 6,
  parameter int RST_SPEED   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              busBusy,
  output logic [DATA_W-1:0] regRdData,
  output ctrlStrobe_t       ctrlStb,
  output logic              sdaPinSel,
  output logic              sclPinSel
);
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_PIN  = 1'b1;

  logic               enReg;
  logic [SPEED_W-1:0] speedReg;
  logic               sdaOwn;
  logic               sclOwn;
  logic               ctrlWr;
  logic               pinWr;

  assign ctrlWr = regWrEn && (regAddr == ADDR_CTRL);
  assign pinWr  = regWrEn && (regAddr == ADDR_PIN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg    <= 1'b0;
      speedReg <= SPEED_W'(RST_SPEED);
    end else if (ctrlWr) begin
      enReg    <= regWrData[EN_BIT];
      speedReg <= regWrData[SPEED_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdaOwn <= 1'b0;
      sclOwn <= 1'b0;
    end else if (pinWr) begin
      sdaOwn <= regWrData[SDA_OWN_BIT];
      sclOwn <= regWrData[SCL_OWN_BIT];
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_CTRL) begin
      regRdData[EN_BIT]        = enReg;
      regRdData[BUSY_BIT]      = busBusy;
      regRdData[SPEED_W-1:0]   = speedReg;
    end else begin
      regRdData[SDA_OWN_BIT]   = sdaOwn;
      regRdData[SCL_OWN_BIT]   = sclOwn;
    end
  end

  assign ctrlStb.enable     = enReg;
  assign ctrlStb.speedCode  = speedReg;
  assign ctrlStb.restartDiv = ctrlWr;
  assign sdaPinSel          = sdaOwn;
  assign sclPinSel          = sclOwn;
endmodule

// File: rtl/i2c_bus_dp.sv
module i2c_bus_dp
  import i2c_bus_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BASE_HALF   = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t ctrlStb,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        busBusy,
  output logic        sclTick
);
  localparam int MAX_CODE = (1 << SPEED_W) - 1;
  localparam int CNT_W    = $clog2(BASE_HALF << MAX_CODE);
  localparam int HALF_W   = CNT_W + 1;
  localparam int LINES    = 2;

  // line monitor: index 0 is SCL, index 1 is SDA
  logic [LINES-1:0] lineRaw;
  logic [LINES-1:0] lineNow;
  logic [LINES-1:0] linePrev;

  assign lineRaw = {sdaIn, sclIn};

  for (genvar i = 0; i < LINES; i++) begin : g_sync
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rstN(rstN),
      .d   (lineRaw[i]),
      .q   (lineNow[i])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) linePrev <= '1;
    else       linePrev <= lineNow;
  end

  logic sclHigh;
  logic startSeen;
  logic stopSeen;

  assign sclHigh   = lineNow[0] && linePrev[0];
  assign startSeen = sclHigh &&  linePrev[1] && !lineNow[1];
  assign stopSeen  = sclHigh && !linePrev[1] &&  lineNow[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                busBusy <= 1'b0;
    else if (!ctrlStb.enable) busBusy <= 1'b0;
    else if (startSeen)       busBusy <= 1'b1;
    else if (stopSeen)        busBusy <= 1'b0;
  end

  // half-bit-period rate generator
  logic [HALF_W-1:0] halfLen;
  logic [CNT_W-1:0]  lastCnt;
  logic [CNT_W-1:0]  divCnt;
  logic              atLast;

  assign halfLen = HALF_W'(BASE_HALF) << ctrlStb.speedCode;
  assign lastCnt = CNT_W'(halfLen - HALF_W'(1));
  assign atLast  = (divCnt == lastCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                      divCnt <= '0;
    else if (!ctrlStb.enable || ctrlStb.restartDiv) divCnt <= '0;
    else if (atLast)                                divCnt <= '0;
    else                                            divCnt <= divCnt + CNT_W'(1);
  end

  assign sclTick = ctrlStb.enable && atLast;
endmodule

// File: rtl/i2c_bus_ctrl.sv
module i2c_bus_ctrl
  import i2c_bus_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int BASE_HALF   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              busBusy,
  output logic              sclTick,
  output logic              sdaPinSel,
  output logic              sclPinSel
);
  ctrlStrobe_t ctrlStb;

  i2c_bus_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .busBusy  (busBusy),
    .regRdData(regRdData),
    .ctrlStb  (ctrlStb),
    .sdaPinSel(sdaPinSel),
    .sclPinSel(sclPinSel)
  );

  i2c_bus_dp #(.SYNC_STAGES(SYNC_STAGES), .BASE_HALF(BASE_HALF)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrlStb(ctrlStb),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .busBusy(busBusy),
    .sclTick(sclTick)
  );
endmodule

// File: rtl/i2c_bus_ctrl_chk.sv
module i2c_bus_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic       regAddr,
  input logic [7:0] regWrData,
  input logic [7:0] regRdData,
  input logic       busBusy,
  input logic       sclTick,
  input logic       sdaPinSel,
  input logic       sclPinSel,
  input logic       ctrlEn
);
  p_tick_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEn |-> !sclTick);

  p_tick_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    sclTick |=> !sclTick);

  p_restart_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regAddr) |=> !sclTick);

  p_busy_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busBusy) |-> $past(ctrlEn));

  p_busy_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEn |=> !busBusy);

  p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !regAddr |-> (regRdData[6:4] == 3'b000));

  p_pin_follow_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr) |=> (sdaPinSel == $past(regWrData[7])) && (sclPinSel == $past(regWrData[6])));
endmodule

bind i2c_bus_ctrl i2c_bus_ctrl_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .regAddr  (regAddr),
  .regWrData(regWrData),
  .regRdData(regRdData),
  .busBusy  (busBusy),
  .sclTick  (sclTick),
  .sdaPinSel(sdaPinSel),
  .sclPinSel(sclPinSel),
  .ctrlEn   (ctrlStb.enable)
);

// File: tb/i2c_bus_ctrl_tb.sv
`timescale 1ns/1ps
module i2c_bus_ctrl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regAddr = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       sclIn = 1'b1;
  logic       sdaIn = 1'b1;
  logic       busBusy, sclTick, sdaPinSel, sclPinSel;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  // bench model
  bit       expEn    = 1'b0;
  bit [2:0] expSpeed = 3'd1;
  bit       expBusy  = 1'b0;
  bit [7:0] expPin   = 8'h00;

  always #4 clk = ~clk;

  i2c_bus_ctrl u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .sclIn(sclIn), .sdaIn(sdaIn),
    .busBusy(busBusy), .sclTick(sclTick), .sdaPinSel(sdaPinSel), .sclPinSel(sclPinSel)
  );

  function automatic int halfOf(bit [2:0] code);
    return 16 << code;
  endfunction

  function automatic bit [7:0] ctrlView(bit en, bit busy, bit [2:0] sp);
    return {en, 3'b000, busy, sp};
  endfunction

  task automatic check(string req, int actual, int expected);
    vectors++;
    if (actual != expected) begin
      misses++;
      $display("FAIL %s actual %0h expected %0h", req, actual, expected);
    end
  endtask

  task automatic regWrite(bit addr, bit [7:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = addr; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
    if (!addr) begin
      expEn = data[7]; expSpeed = data[2:0];
      if (!data[7]) expBusy = 1'b0;
    end else expPin = data & 8'hC0;
  endtask

  task automatic regRead(bit addr, output bit [7:0] v);
    regAddr = addr; #1; v = regRdData;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic doStart();
    sclIn = 1'b0; settle();
    sdaIn = 1'b1; settle();
    sclIn = 1'b1; settle();
    sdaIn = 1'b0; settle();
    if (expEn) expBusy = 1'b1;
  endtask

  task automatic doStop();
    sclIn = 1'b0; settle();
    sdaIn = 1'b0; settle();
    sclIn = 1'b1; settle();
    sdaIn = 1'b1; settle();
    expBusy = 1'b0;
  endtask

  task automatic doWiggle();
    sclIn = 1'b0; settle();
    sdaIn = ~sdaIn; settle();
  endtask

  task automatic checkRegs(string req);
    bit [7:0] v;
    regRead(1'b0, v);
    check(req, v, ctrlView(expEn, expBusy, expSpeed));
    regRead(1'b1, v);
    check(req, v, expPin);
    check(req, busBusy, expBusy);
    check(req, {sdaPinSel, sclPinSel}, expPin[7:6]);
  endtask

  // R3/R4: first tick delay after a control write, then the spacing
  task automatic measureTick(bit [2:0] code, string req);
    int j = 0;
    int k = 0;
    regWrite(1'b0, {1'b1, 4'b0000, code});
    while (!sclTick && j < 5000) begin @(negedge clk); j++; end
    check({req, " first tick"}, j, halfOf(code) - 1);
    @(negedge clk); k = 1;
    check({req, " pulse width"}, sclTick, 0);
    while (!sclTick && k < 5000) begin @(negedge clk); k++; end
    check({req, " spacing"}, k, halfOf(code));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    bit [7:0] v;
    void'($urandom(32'h51A7E));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRead(1'b0, v); check("R1 ctrl reset", v, 8'h01);
    regRead(1'b1, v); check("R1 pin reset", v, 8'h00);
    check("R1 busy reset", busBusy, 0);
    check("R1 tick reset", sclTick, 0);
    check("R1 pinsel reset", {sdaPinSel, sclPinSel}, 0);

    // R2 disabled: no tick, START ignored
    regWrite(1'b0, 8'h00);
    begin
      int seen = 0;
      for (int i = 0; i < 80; i++) begin @(negedge clk); seen += sclTick; end
      check("R2 no tick while off", seen, 0);
    end
    doStart();
    check("R2 start ignored while off", busBusy, 0);
    doStop();

    // R3 all speed codes
    for (int c = 0; c < 8; c++) measureTick(3'(c), "R3");

    // R4 restart mid-period
    regWrite(1'b0, 8'h83);
    repeat (50) @(negedge clk);
    measureTick(3'd3, "R4");

    // R5 START latency
    regWrite(1'b0, 8'h81);
    sclIn = 1'b1; sdaIn = 1'b1; settle();
    @(negedge clk); sdaIn = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R5 busy after two edges", busBusy, 0);
    @(negedge clk);
    check("R5 busy after three edges", busBusy, 1);
    expBusy = 1'b1;
    settle();

    // R7 SDA activity with SCL low keeps busy
    doWiggle(); doWiggle();
    check("R7 busy held", busBusy, 1);

    // R9 read-only busy and unused bits
    regWrite(1'b0, 8'hFA);
    regRead(1'b0, v);
    check("R9 ctrl readback", v, 8'h8A);

    // R6 STOP clears
    doStop();
    check("R6 stop clears", busBusy, 0);
    doWiggle(); doWiggle();
    check("R7 idle held", busBusy, 0);

    // R8 disable forces busy low
    doStart();
    check("R5 start sets", busBusy, 1);
    regWrite(1'b0, 8'h01);
    @(negedge clk);
    check("R8 busy forced low", busBusy, 0);

    // R10 pin ownership
    regWrite(1'b1, 8'hBF);
    check("R10 sda only", {sdaPinSel, sclPinSel}, 2'b10);
    regRead(1'b1, v); check("R10 pin readback", v, 8'h80);

    // random mix against the bench model
    for (int n = 0; n < 60; n++) begin
      case ($urandom % 5)
        0: regWrite(1'b1, 8'($urandom));
        1: regWrite(1'b0, 8'($urandom));
        2: doStart();
        3: doStop();
        default: doWiggle();
      endcase
      @(negedge clk);
      checkRegs("R9 R10 R5 R6 R7 R8 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule